// File: doc/BRIEF.md
# Instruction-Pointer Stride Prefetcher

This block watches the loads a core issues. Each observed load carries two values: the instruction pointer of the load instruction and the data address it touched. A small direct-mapped table is indexed and tagged by the instruction pointer. Each entry learns the distance between successive addresses of its own load instruction.

When one instruction keeps stepping through memory by a fixed non-zero distance, the block offers a prefetch candidate. The candidate is the address just loaded plus the learned distance. The distance is held in two's complement, so both ascending and descending walks are followed.

The block produces candidate addresses only. It has no cache storage and does no fills. One registered request slot with valid/ready drives the downstream consumer. While that slot is stalled, newer candidates are discarded rather than queued.

Top module: `ip_stride_pf`

## Requirements
- R1: After the asynchronous active-low reset, `pf_valid_o` is low and every table entry is empty, so a load after reset never yields a prefetch whatever was learned before the reset.
- R2: The first observed load of an instruction pointer fills its entry: tag, last address, stride 0 and confidence 0. It produces no prefetch.
- R3: The entry index is `obs_ip_i[5:2]` and the tag is `obs_ip_i[31:6]`. A load whose tag differs from the stored tag replaces the whole entry, so two instruction pointers that share an index evict each other's training.
- R4: The step is the current address minus the stored last address, modulo 2^32. A matching non-zero step raises confidence by one. A load that leaves confidence at 2 or more raises `pf_valid_o` on the next clock, with `pf_addr_o` equal to the load address plus the step. For loads A, A+s, A+2s, A+3s, the first prefetch comes after the fourth load and targets A+4s.
- R5: Negative steps train and prefetch like positive ones, giving descending targets.
- R6: A step that differs from the stored stride sets confidence to 0 and stores the new step. Two further matching steps are then needed before prefetching resumes.
- R7: Confidence is 2 bits wide and saturates at 3. Each further matching load keeps prefetching, and one mismatch still drops it to 0.
- R8: A step of zero never raises confidence, so repeated loads of one address never prefetch.
- R9: While `pf_valid_o` is high and `pf_ready_i` is low, `pf_valid_o` and `pf_addr_o` hold. Candidates formed during the stall are discarded and never appear later. After the held request is accepted, with no new candidate, `pf_valid_o` falls.
- R10: Entries at different indices train independently, so interleaved loads of two instructions each keep their own stride.
- R11: If the held request is accepted in the same cycle a new candidate forms, the new candidate occupies the slot on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| obs_valid_i | input | 1 | An observed load is present this cycle |
| obs_ip_i | input | 32 | Instruction pointer of the observed load |
| obs_addr_i | input | 32 | Data address of the observed load |
| pf_valid_o | output | 1 | Prefetch request is valid |
| pf_addr_o | output | 32 | Prefetch target address |
| pf_ready_i | input | 1 | Consumer accepts the prefetch request |

## Verification
Two functions can fall in one cycle. A trained load can produce a fresh candidate while the output slot either stalls or hands off its previous request. The bench provokes the handoff case by keeping ready high through a trained run, so each accepted request is replaced at the same edge; the expected address must then be the new target (R11). It provokes the stall case by lowering ready while a trained load arrives; the output must keep the old address, and after acceptance the slot must go empty instead of showing the dropped target (R9).

// File: rtl/ip_stride_pf_pkg.sv
package ip_stride_pf_pkg;
  typedef enum logic [1:0] {
    TR_ALLOC   = 2'd0,
    TR_AGREE   = 2'd1,
    TR_RESTART = 2'd2
  } train_e;
endpackage

// File: rtl/ip_stride_pf_table.sv
module ip_stride_pf_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 26,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CONF_W  = 2,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_vld_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [ADDR_W-1:0] rd_last_o,
  output logic [ADDR_W-1:0] rd_stride_o,
  output logic [CONF_W-1:0] rd_conf_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [ADDR_W-1:0] wr_last_i,
  input  logic [ADDR_W-1:0] wr_stride_i,
  input  logic [CONF_W-1:0] wr_conf_i
);
  logic              vld_q    [ENTRIES];
  logic [TAG_W-1:0]  tag_q    [ENTRIES];
  logic [ADDR_W-1:0] last_q   [ENTRIES];
  logic [ADDR_W-1:0] stride_q [ENTRIES];
  logic [CONF_W-1:0] conf_q   [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) begin
        vld_q[e]    <= 1'b0;
        tag_q[e]    <= '0;
        last_q[e]   <= '0;
        stride_q[e] <= '0;
        conf_q[e]   <= '0;
      end
    end else if (we_i) begin
      vld_q[wr_idx_i]    <= 1'b1;
      tag_q[wr_idx_i]    <= wr_tag_i;
      last_q[wr_idx_i]   <= wr_last_i;
      stride_q[wr_idx_i] <= wr_stride_i;
      conf_q[wr_idx_i]   <= wr_conf_i;
    end
  end

  assign rd_vld_o    = vld_q[rd_idx_i];
  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_last_o   = last_q[rd_idx_i];
  assign rd_stride_o = stride_q[rd_idx_i];
  assign rd_conf_o   = conf_q[rd_idx_i];
endmodule

// File: rtl/ip_stride_pf_train.sv
module ip_stride_pf_train
  import ip_stride_pf_pkg::*;
#(
  parameter int unsigned TAG_W      = 26,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CONF_W     = 2,
  parameter int unsigned ISSUE_CONF = 2
) (
  input  logic              obs_valid_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ent_vld_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  input  logic [ADDR_W-1:0] ent_last_i,
  input  logic [ADDR_W-1:0] ent_stride_i,
  input  logic [CONF_W-1:0] ent_conf_i,
  output logic [ADDR_W-1:0] upd_stride_o,
  output logic [CONF_W-1:0] upd_conf_o,
  output logic              cand_valid_o,
  output logic [ADDR_W-1:0] cand_addr_o
);
  localparam logic [CONF_W-1:0] CONF_MAX = '1;
  localparam logic [CONF_W-1:0] CONF_THR = CONF_W'(ISSUE_CONF);

  logic [ADDR_W-1:0] step;
  train_e            act;

  assign step = addr_i - ent_last_i;  // two's complement step

  always_comb begin
    if (!ent_vld_i || ent_tag_i != tag_i)            act = TR_ALLOC;
    else if (step == ent_stride_i && step != '0)     act = TR_AGREE;
    else                                             act = TR_RESTART;
  end

  always_comb begin
    unique case (act)
      TR_AGREE: begin
        upd_stride_o = ent_stride_i;
        upd_conf_o   = (ent_conf_i == CONF_MAX) ? CONF_MAX : ent_conf_i + 1'b1;
      end
      TR_RESTART: begin
        upd_stride_o = step;
        upd_conf_o   = '0;
      end
      default: begin
        upd_stride_o = '0;
        upd_conf_o   = '0;
      end
    endcase
  end

  assign cand_valid_o = obs_valid_i && (act == TR_AGREE) && (upd_conf_o >= CONF_THR);
  assign cand_addr_o  = addr_i + step;
endmodule

// File: rtl/ip_stride_pf_out.sv
module ip_stride_pf_out #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_valid_i,
  input  logic [ADDR_W-1:0] cand_addr_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o,
  input  logic              pf_ready_i
);
  logic stalled;
  assign stalled = pf_valid_o && !pf_ready_i;

  // stalled slot holds; candidates arriving meanwhile are discarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_valid_o <= 1'b0;
      pf_addr_o  <= '0;
    end else if (!stalled) begin
      pf_valid_o <= cand_valid_i;
      if (cand_valid_i) pf_addr_o <= cand_addr_i;
    end
  end
endmodule

// File: rtl/ip_stride_pf.sv
module ip_stride_pf #(
  parameter int unsigned IP_W       = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ENTRIES    = 16,
  parameter int unsigned IDX_LSB    = 2,
  parameter int unsigned CONF_W     = 2,
  parameter int unsigned ISSUE_CONF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              obs_valid_i,
  input  logic [IP_W-1:0]   obs_ip_i,
  input  logic [ADDR_W-1:0] obs_addr_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o,
  input  logic              pf_ready_i
);
  localparam int unsigned IDX_W   = $clog2(ENTRIES);
  localparam int unsigned TAG_LSB = IDX_LSB + IDX_W;
  localparam int unsigned TAG_W   = IP_W - TAG_LSB;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              ent_vld;
  logic [TAG_W-1:0]  ent_tag;
  logic [ADDR_W-1:0] ent_last, ent_stride, upd_stride, cand_addr;
  logic [CONF_W-1:0] ent_conf, upd_conf;
  logic              cand_valid;

  assign idx = obs_ip_i[IDX_LSB +: IDX_W];
  assign tag = obs_ip_i[IP_W-1:TAG_LSB];

  generate
    if (IDX_LSB > 0) begin : g_low_bits
      logic unused_ip_low;
      assign unused_ip_low = ^obs_ip_i[IDX_LSB-1:0];
    end
  endgenerate

  ip_stride_pf_table #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .CONF_W(CONF_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (idx),
    .rd_vld_o   (ent_vld),
    .rd_tag_o   (ent_tag),
    .rd_last_o  (ent_last),
    .rd_stride_o(ent_stride),
    .rd_conf_o  (ent_conf),
    .we_i       (obs_valid_i),
    .wr_idx_i   (idx),
    .wr_tag_i   (tag),
    .wr_last_i  (obs_addr_i),
    .wr_stride_i(upd_stride),
    .wr_conf_i  (upd_conf)
  );

  ip_stride_pf_train #(
    .TAG_W(TAG_W), .ADDR_W(ADDR_W), .CONF_W(CONF_W), .ISSUE_CONF(ISSUE_CONF)
  ) u_train (
    .obs_valid_i (obs_valid_i),
    .tag_i       (tag),
    .addr_i      (obs_addr_i),
    .ent_vld_i   (ent_vld),
    .ent_tag_i   (ent_tag),
    .ent_last_i  (ent_last),
    .ent_stride_i(ent_stride),
    .ent_conf_i  (ent_conf),
    .upd_stride_o(upd_stride),
    .upd_conf_o  (upd_conf),
    .cand_valid_o(cand_valid),
    .cand_addr_o (cand_addr)
  );

  ip_stride_pf_out #(.ADDR_W(ADDR_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cand_valid_i(cand_valid),
    .cand_addr_i (cand_addr),
    .pf_valid_o  (pf_valid_o),
    .pf_addr_o   (pf_addr_o),
    .pf_ready_i  (pf_ready_i)
  );
endmodule

// File: rtl/ip_stride_pf_chk.sv
module ip_stride_pf_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              obs_valid_i,
  input logic [ADDR_W-1:0] obs_addr_i,
  input logic              pf_valid_o,
  input logic [ADDR_W-1:0] pf_addr_o,
  input logic              pf_ready_i
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_o && !pf_ready_i) |=> (pf_valid_o && $stable(pf_addr_o))); // R9

  AST_IDLE_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!obs_valid_i && (!pf_valid_o || pf_ready_i)) |=> !pf_valid_o); // R9

  AST_FRESH_FROM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_o && $past(!pf_valid_o || pf_ready_i)) |-> $past(obs_valid_i)); // R4

  AST_NONZERO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_o && $past(!pf_valid_o || pf_ready_i)) |-> (pf_addr_o != $past(obs_addr_i))); // R8
endmodule

bind ip_stride_pf ip_stride_pf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .obs_valid_i(obs_valid_i),
  .obs_addr_i (obs_addr_i),
  .pf_valid_o (pf_valid_o),
  .pf_addr_o  (pf_addr_o),
  .pf_ready_i (pf_ready_i)
);

// File: tb/ip_stride_pf_test.sv
module ip_stride_pf_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        obs_valid_i = 1'b0;
  logic [31:0] obs_ip_i = '0;
  logic [31:0] obs_addr_i = '0;
  logic        pf_valid_o;
  logic [31:0] pf_addr_o;
  logic        pf_ready_i = 1'b1;

  int compared = 0;
  int mismatched = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  ip_stride_pf uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .obs_valid_i(obs_valid_i), .obs_ip_i(obs_ip_i),
    .obs_addr_i(obs_addr_i), .pf_valid_o(pf_valid_o), .pf_addr_o(pf_addr_o),
    .pf_ready_i(pf_ready_i)
  );

  typedef struct packed {
    logic [31:0] ip;
    logic [31:0] addr;
    logic        ev;
    logic [31:0] ea;
    logic [7:0]  req;
  } vec_t;

  localparam logic [31:0] IP_A = 32'h0000_1004;  // index 1
  localparam logic [31:0] IP_B = 32'h0000_2008;  // index 2
  localparam logic [31:0] IP_C = 32'h0000_3004;  // index 1, other tag
  localparam logic [31:0] IP_D = 32'h0000_400C;  // index 3
  localparam logic [31:0] IP_E = 32'h0000_5010;  // index 4

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{IP_A, 32'h100,  1'b0, 32'h0,    8'd2},   // R2 allocate
    '{IP_A, 32'h140,  1'b0, 32'h0,    8'd4},
    '{IP_A, 32'h180,  1'b0, 32'h0,    8'd4},
    '{IP_A, 32'h1C0,  1'b1, 32'h200,  8'd4},   // R4 first prefetch
    '{IP_A, 32'h200,  1'b1, 32'h240,  8'd11},  // R11 accept + new
    '{IP_A, 32'h240,  1'b1, 32'h280,  8'd7},   // R7 saturated
    '{IP_A, 32'h300,  1'b0, 32'h0,    8'd6},   // R6 mismatch
    '{IP_A, 32'h340,  1'b0, 32'h0,    8'd6},
    '{IP_A, 32'h380,  1'b0, 32'h0,    8'd6},
    '{IP_A, 32'h3C0,  1'b1, 32'h400,  8'd6},
    '{IP_B, 32'h9000, 1'b0, 32'h0,    8'd2},
    '{IP_B, 32'h8FF0, 1'b0, 32'h0,    8'd5},   // R5 descending
    '{IP_B, 32'h8FE0, 1'b0, 32'h0,    8'd5},
    '{IP_B, 32'h8FD0, 1'b1, 32'h8FC0, 8'd5},
    '{IP_A, 32'h400,  1'b1, 32'h440,  8'd10},  // R10 interleave
    '{IP_B, 32'h8FC0, 1'b1, 32'h8FB0, 8'd10},
    '{IP_C, 32'h5000, 1'b0, 32'h0,    8'd3},   // R3 evicts A
    '{IP_A, 32'h440,  1'b0, 32'h0,    8'd3},
    '{IP_A, 32'h480,  1'b0, 32'h0,    8'd3},
    '{IP_D, 32'h700,  1'b0, 32'h0,    8'd8},   // R8 zero step
    '{IP_D, 32'h700,  1'b0, 32'h0,    8'd8},
    '{IP_D, 32'h700,  1'b0, 32'h0,    8'd8},
    '{IP_D, 32'h700,  1'b0, 32'h0,    8'd8},
    '{IP_D, 32'h700,  1'b0, 32'h0,    8'd8}
  };

  task automatic check(input logic ev, input logic [31:0] ea, input int req);
    compared++;
    if (pf_valid_o !== ev || (ev && pf_addr_o !== ea)) begin
      mismatched++;
      $display("FAIL R%0d: got valid=%0b addr=%h, expected valid=%0b addr=%h",
               req, pf_valid_o, pf_addr_o, ev, ea);
    end
  endtask

  // called at a negedge; result visible at the following negedge
  task automatic step(input logic v, input logic [31:0] ip, input logic [31:0] a, input logic rdy);
    obs_valid_i = v;
    obs_ip_i    = ip;
    obs_addr_i  = a;
    pf_ready_i  = rdy;
    @(posedge clk_i);
    @(negedge clk_i);
    obs_valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    mismatched++;
    $display("FAIL R1: watchdog expired, got no completion, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(1'b0, 32'h0, 1);  // R1 during reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1'b0, 32'h0, 1);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      step(1'b1, VECS[i].ip, VECS[i].addr, 1'b1);
      check(VECS[i].ev, VECS[i].ea, int'(VECS[i].req));
    end

    // R9 stall: held, candidate dropped, slot empties after accept
    step(1'b1, IP_E, 32'h00, 1'b1);
    step(1'b1, IP_E, 32'h10, 1'b1);
    step(1'b1, IP_E, 32'h20, 1'b1);
    step(1'b1, IP_E, 32'h30, 1'b0);
    check(1'b1, 32'h40, 9);
    step(1'b1, IP_E, 32'h40, 1'b0);
    check(1'b1, 32'h40, 9);
    step(1'b0, 32'h0, 32'h0, 1'b0);
    check(1'b1, 32'h40, 9);
    step(1'b0, 32'h0, 32'h0, 1'b1);
    check(1'b0, 32'h0, 9);

    // R1 reset clears learned state: A would reach confidence 2 otherwise
    step(1'b1, IP_A, 32'h4C0, 1'b1);
    check(1'b0, 32'h0, 1);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(1'b0, 32'h0, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(1'b1, IP_A, 32'h500, 1'b1);
    check(1'b0, 32'h0, 1);
    step(1'b1, IP_A, 32'h540, 1'b1);
    check(1'b0, 32'h0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule